// File: doc/BRIEF.md
# Byte-Wide SPI Master/Slave Port

This block is an SPI port for a small processor. The processor reaches it through three byte-wide registers on a simple bus: control, status and data. In the master role the port generates the serial clock from the peripheral clock and starts a frame whenever the data register is written. In the slave role it follows a clock and select driven by an external master. In both roles every frame is 8 bits long, is sent most significant bit first, and is full-duplex. One byte leaves on the output data line while another arrives on the input data line.

A received byte is copied out of the shift register into a separate receive buffer, and reading the data register returns that buffer. Three sticky flags report the state of the port: end of frame, write collision and mode fault. One interrupt line is raised while the end-of-frame flag or the mode-fault flag is set. The pads are modelled as data-out and output-enable pairs, so the port is tri-state only when an enclosing pad ring adds the drivers.

Top module: `spi_port`

## Requirements
- R1: Control register (regSel 0) reads back what was written, bit 7 down to 0 as {rate2, enable, ignoreSelect, master, cpol, cpha, rate1, rate0}. It resets to 0.
- R2: Status register (regSel 1) reads {frameDone, collision, 0, modeFault, 0000}. Bits 5 and 3..0 always read 0.
- R3: In master mode the SCK period is the peripheral clock period times 4, 8, 16, 32, 64 or 128, for rate codes {rate2,rate1,rate0} 0 to 5. Codes 6 and 7 give /128. The first SCK edge comes half a period after the data write that starts the frame.
- R4: SCK idles at cpol. With cpha=0 data is sampled on the 1st, 3rd … edges and changed on the even edges. With cpha=1 data is changed on the 3rd, 5th … edges and sampled on the even edges. Frames go MSB first, and the first bit is valid from the start of the frame.
- R5: One clock after the 16th SCK edge, frameDone sets, irq rises, and the data register returns the received byte.
- R6: As a selected slave (master=0, ssN low), the port follows SCK and mosiIn with the same cpol/cpha rules. It drives the byte last written to the data register on misoOut and receives 8 bits from mosiIn.
- R7: An unselected slave (ssN high, ignoreSelect=0) keeps misoOe low and ignores SCK. No flag sets and the receive buffer keeps its old value.
- R8: With ignoreSelect=1, a slave behaves as selected whatever ssN is, and a master ignores ssN low and raises no mode fault.
- R9: A data write while a frame is in progress sets collision. The write is discarded and the frame in progress finishes unchanged.
- R10: When ssN is low in master mode with ignoreSelect=0, modeFault sets, the master bit clears, sckOe and mosiOe drop and irq rises.
- R11: The flags clear only when a status read that sees a flag set is followed by an access to the data register. A data access with no status read before it leaves them set.
- R12: With enable=0 the port drives none of sckOe, mosiOe or misoOe, and a data write starts no frame.
- R13: An enabled master drives sckOe and mosiOe and not misoOe. An enabled, selected slave drives misoOe only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 2 | Register select: 0 control, 1 status, 2 data |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (drives read side effects) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request: frameDone or modeFault |
| sckIn | input | 1 | Serial clock from an external master |
| sckOut | output | 1 | Serial clock generated in master mode |
| sckOe | output | 1 | Output enable for sckOut |
| mosiIn | input | 1 | Master-to-slave data in (slave mode) |
| mosiOut | output | 1 | Master-to-slave data out (master mode) |
| mosiOe | output | 1 | Output enable for mosiOut |
| misoIn | input | 1 | Slave-to-master data in (master mode) |
| misoOut | output | 1 | Slave-to-master data out (slave mode) |
| misoOe | output | 1 | Output enable for misoOut |
| ssN | input | 1 | Active-low slave select |

## Verification
The bench runs a master frame at every rate code, including the two codes that clamp to /128, and crosses them with all four polarity and phase pairs. A divider that is off by one half-period, or a wrong phase, shows up at once in the level of SCK or MOSI on some clock. The collision case writes in the middle of a frame: a design that accepted the write would corrupt MOSI, and one that missed it would leave the collision flag clear. The mode fault, the unselected-slave case and the select-override case cover a core that keeps driving its pins after losing the bus, or that samples a bus it was not selected for. Reading data before status checks a flag-clear sequence that lets a flag go too early.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } regSel_e;

  // Configuration fields decoded from the control register
  typedef struct packed {
    logic       en;
    logic       master;
    logic       ignoreSel;
    logic       cpol;
    logic       cpha;
    logic [2:0] rate;
  } spiCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadTx;       // copy wrData into the shift register
    logic startMaster;  // launch a master frame
    logic abort;        // drop any frame in progress
  } spiStrobe_t;

endpackage

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              busy,
  input  logic              frameDone,
  input  logic              ssLow,
  input  logic [BYTE_W-1:0] rxData,
  output spiCfg_t           cfg,
  output spiStrobe_t        strb,
  output logic [BYTE_W-1:0] rdData,
  output logic              flagDone,
  output logic              flagColl,
  output logic              flagFault,
  output logic              irq
);

  logic [2:0] rateQ;
  logic       enQ, ignoreSelQ, masterQ, cpolQ, cphaQ;
  logic       clearArmed;

  logic wrCtrl, wrDataReg, rdStat, dataAccess;
  logic faultSet, collSet, clearNow, modeChange;

  assign wrCtrl     = wrEn && (regSel == REG_CTRL);
  assign wrDataReg  = wrEn && (regSel == REG_DATA);
  assign rdStat     = rdEn && (regSel == REG_STAT);
  assign dataAccess = (wrEn || rdEn) && (regSel == REG_DATA);

  assign faultSet   = enQ && masterQ && !ignoreSelQ && ssLow;
  assign collSet    = wrDataReg && busy;
  assign clearNow   = dataAccess && clearArmed;
  assign modeChange = wrCtrl && ((wrData[6] != enQ) || (wrData[4] != masterQ));

  // Control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateQ      <= '0;
      enQ        <= 1'b0;
      ignoreSelQ <= 1'b0;
      masterQ    <= 1'b0;
      cpolQ      <= 1'b0;
      cphaQ      <= 1'b0;
    end else begin
      if (wrCtrl) begin
        rateQ      <= {wrData[7], wrData[1], wrData[0]};
        enQ        <= wrData[6];
        ignoreSelQ <= wrData[5];
        masterQ    <= wrData[4];
        cpolQ      <= wrData[3];
        cphaQ      <= wrData[2];
      end
      if (faultSet) begin
        masterQ <= 1'b0;
      end
    end
  end

  // Sticky flags and the two-step clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagDone   <= 1'b0;
      flagColl   <= 1'b0;
      flagFault  <= 1'b0;
      clearArmed <= 1'b0;
    end else begin
      if (rdStat && (flagDone || flagColl || flagFault)) begin
        clearArmed <= 1'b1;
      end else if (dataAccess) begin
        clearArmed <= 1'b0;
      end

      if (frameDone)      flagDone <= 1'b1;
      else if (clearNow)  flagDone <= 1'b0;

      if (collSet)        flagColl <= 1'b1;
      else if (clearNow)  flagColl <= 1'b0;

      if (faultSet)       flagFault <= 1'b1;
      else if (clearNow)  flagFault <= 1'b0;
    end
  end

  always_comb begin
    cfg.en        = enQ;
    cfg.master    = masterQ;
    cfg.ignoreSel = ignoreSelQ;
    cfg.cpol      = cpolQ;
    cfg.cpha      = cphaQ;
    cfg.rate      = rateQ;
  end

  always_comb begin
    strb.loadTx      = wrDataReg && !busy;
    strb.startMaster = wrDataReg && !busy && enQ && masterQ && !faultSet;
    strb.abort       = faultSet || modeChange;
  end

  always_comb begin
    case (regSel)
      REG_CTRL: rdData = {rateQ[2], enQ, ignoreSelQ, masterQ, cpolQ, cphaQ, rateQ[1], rateQ[0]};
      REG_STAT: rdData = {flagDone, flagColl, 1'b0, flagFault, 4'b0000};
      REG_DATA: rdData = rxData;
      default:  rdData = '0;
    endcase
  end

  assign irq = flagDone || flagFault;

endmodule

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RATE_CODES  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiCfg_t           cfg,
  input  spiStrobe_t        strb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  input  logic              ssN,
  output logic              sckOut,
  output logic              sckOe,
  output logic              mosiOut,
  output logic              mosiOe,
  output logic              misoOut,
  output logic              misoOe,
  output logic              busy,
  output logic              frameDone,
  output logic              ssLow,
  output logic [BYTE_W-1:0] rxData
);

  localparam int              EDGES    = 2 * BYTE_W;
  localparam int              ECNT_W   = $clog2(EDGES);
  localparam int              HCNT_W   = $clog2(2 << (RATE_CODES - 1));
  localparam logic [2:0]      RATE_TOP = 3'(RATE_CODES - 1);
  localparam logic [HCNT_W:0] MIN_HALF = (HCNT_W + 1)'(2);
  localparam logic [ECNT_W-1:0] LAST_EDGE = ECNT_W'(EDGES - 1);

  // Input synchronisers: {ssN, sckIn, mosiIn}
  logic [2:0] syncQ [SYNC_STAGES];
  logic       ssSync, sckSync, mosiSync, sckPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= 3'b100;
      sckPrev <= 1'b0;
    end else begin
      syncQ[0] <= {ssN, sckIn, mosiIn};
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      sckPrev <= sckSync;
    end
  end

  assign ssSync   = syncQ[SYNC_STAGES-1][2];
  assign sckSync  = syncQ[SYNC_STAGES-1][1];
  assign mosiSync = syncQ[SYNC_STAGES-1][0];
  assign ssLow    = !ssSync;

  // Prescaler: half SCK period = 2 << rate, clamped at the top code
  logic [2:0]        rateEff;
  logic [HCNT_W:0]   halfSpan;
  logic [HCNT_W-1:0] halfLim, halfCnt;

  assign rateEff  = (cfg.rate > RATE_TOP) ? RATE_TOP : cfg.rate;
  assign halfSpan = MIN_HALF << rateEff;
  assign halfLim  = HCNT_W'(halfSpan - 1'b1);

  // Frame engine
  logic              mBusy, sckLevel, sampleBit;
  logic [ECNT_W-1:0] edgeCnt;
  logic [BYTE_W-1:0] shiftReg, rxBuf;
  logic              mActive, slaveSel, mEdge, sEdge, anyEdge, leading, lastEdge;
  logic              inBit, sampleNow, shiftNow, finalNow;
  logic [BYTE_W-1:0] shiftNext;

  assign mActive   = cfg.en && cfg.master;
  assign slaveSel  = cfg.en && !cfg.master && (cfg.ignoreSel || !ssSync);
  assign mEdge     = mBusy && (halfCnt == halfLim);
  assign sEdge     = slaveSel && (sckSync != sckPrev);
  assign anyEdge   = mEdge || sEdge;
  assign leading   = !edgeCnt[0];
  assign lastEdge  = (edgeCnt == LAST_EDGE);
  assign inBit     = cfg.master ? misoIn : mosiSync;
  assign sampleNow = anyEdge && (cfg.cpha ? !leading : leading);
  assign shiftNow  = anyEdge && !lastEdge &&
                     (cfg.cpha ? (leading && (edgeCnt != '0)) : !leading);
  assign finalNow  = anyEdge && lastEdge;
  assign shiftNext = {shiftReg[BYTE_W-2:0], cfg.cpha ? inBit : sampleBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy     <= 1'b0;
      sckLevel  <= 1'b0;
      sampleBit <= 1'b0;
      edgeCnt   <= '0;
      halfCnt   <= '0;
      shiftReg  <= '0;
      rxBuf     <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= finalNow && !strb.abort;
      if (strb.abort) begin
        mBusy    <= 1'b0;
        sckLevel <= 1'b0;
        edgeCnt  <= '0;
        halfCnt  <= '0;
      end else if (strb.loadTx) begin
        shiftReg <= wrData;
        if (strb.startMaster) begin
          mBusy    <= 1'b1;
          sckLevel <= 1'b0;
          edgeCnt  <= '0;
          halfCnt  <= '0;
        end
      end else begin
        if (mBusy) halfCnt <= mEdge ? '0 : halfCnt + 1'b1;
        if (mEdge) sckLevel <= !sckLevel;
        if (sampleNow) sampleBit <= inBit;
        if (shiftNow) shiftReg <= {shiftReg[BYTE_W-2:0], sampleBit};
        if (finalNow) begin
          shiftReg <= shiftNext;
          rxBuf    <= shiftNext;
          edgeCnt  <= '0;
          mBusy    <= 1'b0;
        end else if (anyEdge) begin
          edgeCnt <= edgeCnt + 1'b1;
        end
        if (!slaveSel && !mBusy) edgeCnt <= '0;
      end
    end
  end

  assign busy    = mBusy || (edgeCnt != '0);
  assign rxData  = rxBuf;
  assign sckOe   = mActive;
  assign sckOut  = cfg.cpol ^ sckLevel;
  assign mosiOe  = mActive;
  assign mosiOut = shiftReg[BYTE_W-1];
  assign misoOe  = slaveSel;
  assign misoOut = shiftReg[BYTE_W-1];

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RATE_CODES  = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irq,
  input  logic       sckIn,
  output logic       sckOut,
  output logic       sckOe,
  input  logic       mosiIn,
  output logic       mosiOut,
  output logic       mosiOe,
  input  logic       misoIn,
  output logic       misoOut,
  output logic       misoOe,
  input  logic       ssN
);

  spiCfg_t           cfg;
  spiStrobe_t        strb;
  logic              busy, frameDone, ssLow;
  logic              flagDone, flagColl, flagFault;
  logic [BYTE_W-1:0] rxData;

  spi_port_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regSel    (regSel),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .wrData    (wrData),
    .busy      (busy),
    .frameDone (frameDone),
    .ssLow     (ssLow),
    .rxData    (rxData),
    .cfg       (cfg),
    .strb      (strb),
    .rdData    (rdData),
    .flagDone  (flagDone),
    .flagColl  (flagColl),
    .flagFault (flagFault),
    .irq       (irq)
  );

  spi_port_dp #(
    .SYNC_STAGES (SYNC_STAGES),
    .RATE_CODES  (RATE_CODES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfg       (cfg),
    .strb      (strb),
    .wrData    (wrData),
    .sckIn     (sckIn),
    .mosiIn    (mosiIn),
    .misoIn    (misoIn),
    .ssN       (ssN),
    .sckOut    (sckOut),
    .sckOe     (sckOe),
    .mosiOut   (mosiOut),
    .mosiOe    (mosiOe),
    .misoOut   (misoOut),
    .misoOe    (misoOe),
    .busy      (busy),
    .frameDone (frameDone),
    .ssLow     (ssLow),
    .rxData    (rxData)
  );

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] regSel,
  input logic       wrEn,
  input logic       busy,
  input logic       frameDone,
  input logic       ssLow,
  input logic       spen,
  input logic       ignoreSel,
  input logic       cpol,
  input logic       flagDone,
  input logic       flagColl,
  input logic       flagFault,
  input logic       sckOut,
  input logic       sckOe,
  input logic       mosiOe,
  input logic       misoOe
);

  // R5: a finished frame always leaves the done flag set
  a_r5_done_after_frame: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> flagDone);

  // R9: a data write during a frame always flags a collision
  a_r9_collision_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == 2'd2 && busy) |=> flagColl);

  // R10: a master that sees select low gives up the bus next cycle
  a_r10_fault_releases_bus: assert property (@(posedge clk) disable iff (!rstN)
    (sckOe && ssLow && !ignoreSel) |=> (!sckOe && !mosiOe && flagFault));

  // R13: never master and slave outputs at once
  a_r13_single_role: assert property (@(posedge clk) disable iff (!rstN)
    !(misoOe && (sckOe || mosiOe)));

  // R3: idle master clock sits at the polarity level
  a_r3_idle_sck_level: assert property (@(posedge clk) disable iff (!rstN)
    (sckOe && !busy) |-> (sckOut == cpol));

  // R12: a disabled port drives nothing
  a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !spen |-> !(sckOe || mosiOe || misoOe));

endmodule

bind spi_port spi_port_chk u_spiChk (
  .clk       (clk),
  .rstN      (rstN),
  .regSel    (regSel),
  .wrEn      (wrEn),
  .busy      (busy),
  .frameDone (frameDone),
  .ssLow     (ssLow),
  .spen      (cfg.en),
  .ignoreSel (cfg.ignoreSel),
  .cpol      (cfg.cpol),
  .flagDone  (flagDone),
  .flagColl  (flagColl),
  .flagFault (flagFault),
  .sckOut    (sckOut),
  .sckOe     (sckOe),
  .mosiOe    (mosiOe),
  .misoOe    (misoOe)
);

// File: tb/test_spi_port.sv
`timescale 1ns/1ps
module test_spi_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       irq;
  logic       sckIn = 1'b0;
  logic       sckOut, sckOe;
  logic       mosiIn = 1'b0;
  logic       mosiOut, mosiOe;
  logic       misoIn = 1'b0;
  logic       misoOut, misoOe;
  logic       ssN = 1'b1;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;  // 125 MHz

  spi_port i_spi_port (
    .clk (clk), .rstN (rstN), .regSel (regSel), .wrEn (wrEn), .rdEn (rdEn),
    .wrData (wrData), .rdData (rdData), .irq (irq),
    .sckIn (sckIn), .sckOut (sckOut), .sckOe (sckOe),
    .mosiIn (mosiIn), .mosiOut (mosiOut), .mosiOe (mosiOe),
    .misoIn (misoIn), .misoOut (misoOut), .misoOe (misoOe),
    .ssN (ssN)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wrReg(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk);
    regSel = s; wrData = v; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk);
    regSel = s; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- behavioural master reference model ----------------
  logic [7:0] mCtrl = 8'h00;
  logic [7:0] mTx = 8'h00, mSlv = 8'h00;
  bit         mActive = 1'b0;
  bit         mCpol = 1'b0, mCpha = 1'b0;
  int         mCnt = 0, mHalf = 2;
  int         kEdge, bitIdx, rr;

  always @(posedge clk) begin
    if (rstN) begin
      if (wrEn && regSel == 2'd0) mCtrl = wrData;
      if (mActive) begin
        if (mCnt == 16 * mHalf + 1) mActive = 1'b0;
        else mCnt++;
      end else if (wrEn && regSel == 2'd2 && mCtrl[6] && mCtrl[4]) begin
        rr = {mCtrl[7], mCtrl[1], mCtrl[0]};
        if (rr > 5) rr = 5;
        mHalf   = 2 << rr;
        mCpol   = mCtrl[3];
        mCpha   = mCtrl[2];
        mTx     = wrData;
        mCnt    = 0;
        mActive = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && mActive) begin
      kEdge = mCnt / mHalf;
      if (kEdge > 16) kEdge = 16;
      if (mCpha) bitIdx = (kEdge == 0) ? 0 : (kEdge - 1) / 2;
      else       bitIdx = kEdge / 2;
      if (bitIdx > 7) bitIdx = 7;
      chk("R3/R4 sck level", {7'd0, sckOut}, {7'd0, mCpol ^ kEdge[0]});
      if (kEdge < 16) chk("R4 mosi bit", {7'd0, mosiOut}, {7'd0, mTx[7 - bitIdx]});
      chk("R5 irq timing", {7'd0, irq}, {7'd0, (mCnt == 16 * mHalf + 1)});
      misoIn = mSlv[7 - bitIdx];
    end
  end

  // ---------------- slave-side stimulus ----------------
  localparam int H = 8;

  task automatic slaveXfer(input bit cpol, input bit cpha, input logic [7:0] mByte,
                           input logic [7:0] sByte, input bit doChk);
    for (int i = 0; i < 8; i++) begin
      if (!cpha) begin
        mosiIn = mByte[7 - i];
        waitClk(H);
        if (doChk) chk("R6 slave miso bit", {7'd0, misoOut}, {7'd0, sByte[7 - i]});
        sckIn = !cpol;
        waitClk(H);
        sckIn = cpol;
      end else begin
        sckIn  = !cpol;
        mosiIn = mByte[7 - i];
        waitClk(H);
        if (doChk) chk("R6 slave miso bit", {7'd0, misoOut}, {7'd0, sByte[7 - i]});
        sckIn = cpol;
        waitClk(H);
      end
    end
    waitClk(H);
  endtask

  task automatic runMaster(input logic [7:0] tx, input logic [7:0] slv);
    logic [7:0] v;
    mSlv = slv;
    wrReg(2'd2, tx);
    while (mActive) @(negedge clk);
    chk("R5 irq after frame", {7'd0, irq}, 8'd1);
    rdReg(2'd1, v); chk("R2 status done", v, 8'h80);
    rdReg(2'd2, v); chk("R4 received byte", v, slv);
    rdReg(2'd1, v); chk("R11 cleared", v, 8'h00);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] c;
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);

    // R1 / R12 reset state
    rdReg(2'd0, v); chk("R1 ctrl reset", v, 8'h00);
    rdReg(2'd1, v); chk("R2 status reset", v, 8'h00);
    chk("R12 oe at reset", {5'd0, sckOe, mosiOe, misoOe}, 8'h00);
    chk("R5 irq at reset", {7'd0, irq}, 8'h00);

    // R12 disabled: data write starts nothing
    wrReg(2'd2, 8'hA5);
    waitClk(20);
    chk("R12 no drive when off", {5'd0, sckOe, mosiOe, misoOe}, 8'h00);
    rdReg(2'd1, v); chk("R12 no frame when off", v, 8'h00);

    // R1 readback
    wrReg(2'd0, 8'h3D);
    rdReg(2'd0, v); chk("R1 ctrl readback", v, 8'h3D);
    wrReg(2'd0, 8'h00);

    // R3/R4/R5: every rate code, all cpol/cpha pairs
    for (int r = 0; r < 8; r++) begin
      c = {r[2], 1'b1, 1'b0, 1'b1, r[0], r[1], r[1], r[0]};
      wrReg(2'd0, c);
      chk("R13 master oe", {5'd0, sckOe, mosiOe, misoOe}, 8'h06);
      runMaster(8'h35 + 8'(r * 37), 8'hC9 ^ 8'(r * 19));
    end

    // R9 collision mid-frame
    wrReg(2'd0, 8'h50);
    mSlv = 8'hC3;
    wrReg(2'd2, 8'h3C);
    waitClk(5);
    wrReg(2'd2, 8'hFF);
    while (mActive) @(negedge clk);
    rdReg(2'd1, v); chk("R9 collision flag", v, 8'hC0);
    rdReg(2'd2, v); chk("R9 frame unchanged", v, 8'hC3);
    rdReg(2'd1, v); chk("R11 all cleared", v, 8'h00);

    // R11 data access without status read keeps flags
    mSlv = 8'h81;
    wrReg(2'd2, 8'h18);
    while (mActive) @(negedge clk);
    rdReg(2'd2, v); chk("R11 rx before clear", v, 8'h81);
    rdReg(2'd1, v); chk("R11 flag kept", v, 8'h80);
    rdReg(2'd2, v);
    rdReg(2'd1, v); chk("R11 flag cleared", v, 8'h00);

    // R10 mode fault
    wrReg(2'd0, 8'h50);
    ssN = 1'b0;
    waitClk(6);
    chk("R10 bus released", {6'd0, sckOe, mosiOe}, 8'h00);
    chk("R10 irq", {7'd0, irq}, 8'h01);
    rdReg(2'd1, v); chk("R10 fault flag", v, 8'h10);
    rdReg(2'd0, v); chk("R10 master cleared", v, 8'h40);
    ssN = 1'b1;
    rdReg(2'd2, v);
    rdReg(2'd1, v); chk("R11 fault cleared", v, 8'h00);

    // R8 master ignores select when ignoreSelect=1
    wrReg(2'd0, 8'h70);
    ssN = 1'b0;
    waitClk(6);
    chk("R8 no fault", {7'd0, irq}, 8'h00);
    runMaster(8'h6E, 8'h2B);
    ssN = 1'b1;

    // R6 slave, cpol=0 cpha=0
    wrReg(2'd0, 8'h40);
    wrReg(2'd2, 8'h96);
    sckIn = 1'b0;
    ssN = 1'b0;
    waitClk(4);
    chk("R13 slave oe", {5'd0, sckOe, mosiOe, misoOe}, 8'h01);
    slaveXfer(1'b0, 1'b0, 8'h6B, 8'h96, 1'b1);
    chk("R6 irq", {7'd0, irq}, 8'h01);
    rdReg(2'd1, v); chk("R6 done flag", v, 8'h80);
    rdReg(2'd2, v); chk("R6 slave rx", v, 8'h6B);
    ssN = 1'b1;

    // R6 slave, cpol=1 cpha=1
    wrReg(2'd0, 8'h4C);
    wrReg(2'd2, 8'h1E);
    sckIn = 1'b1;
    waitClk(4);
    ssN = 1'b0;
    waitClk(4);
    slaveXfer(1'b1, 1'b1, 8'hE1, 8'h1E, 1'b1);
    rdReg(2'd1, v); chk("R6 done flag cpha1", v, 8'h80);
    rdReg(2'd2, v); chk("R6 slave rx cpha1", v, 8'hE1);
    ssN = 1'b1;

    // R7 unselected slave ignores the bus
    wrReg(2'd0, 8'h40);
    sckIn = 1'b0;
    waitClk(4);
    wrReg(2'd2, 8'h55);
    chk("R7 miso not driven", {7'd0, misoOe}, 8'h00);
    slaveXfer(1'b0, 1'b0, 8'h0F, 8'h00, 1'b0);
    chk("R7 no irq", {7'd0, irq}, 8'h00);
    rdReg(2'd1, v); chk("R7 no flag", v, 8'h00);
    rdReg(2'd2, v); chk("R7 rx kept", v, 8'hE1);

    // R8 slave selected by override with ssN high
    wrReg(2'd0, 8'h60);
    wrReg(2'd2, 8'hA3);
    waitClk(4);
    chk("R8 slave oe", {7'd0, misoOe}, 8'h01);
    slaveXfer(1'b0, 1'b0, 8'h5C, 8'hA3, 1'b1);
    rdReg(2'd1, v); chk("R8 done flag", v, 8'h80);
    rdReg(2'd2, v); chk("R8 slave rx", v, 8'h5C);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule